// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block is the tag and state engine of a set-associative cache. A request carries a physical address plus read, write or prefetch intent. One cycle later the block reports hit or miss and the way it used. When the next level must act, it also raises a line fill, a writeback of a dirty victim or a write-through. For every line it holds a tag, a MESI state, an age rank within its set and a prefetch-pending flag. Event counters run alongside. The data array sits outside the block.

Write-through and no-write-allocate are run-time policy inputs. Coherence changes arrive on a snoop-update port that rewrites the state of a matching line. A flush command walks every line in turn, one line per cycle. It writes back dirty lines, invalidates all of them and holds off requests while it runs. A combinational peek port shows any line's tag, state, age and flag.

Top module: `cache_tag_ctrl`

## Requirements
- R1: After reset every line is Invalid (state code 0; codes are I=0, S=1, E=2, M=3) with its prefetch flag clear. Way w of every set has age w. All counters read zero and busy, resp_valid, fill_valid, wb_valid and wt_valid are low.
- R2: A request accepted while not busy gives resp_valid exactly one cycle later. resp_hit is high when a non-Invalid way of the set selected by address bits [OFF+IDX-1:OFF] (OFF=log2 of the 64-byte line) holds the request's tag, and resp_way names that way.
- R3: A demand access or an allocating miss sets the touched way's age to 0. Every way of that set whose age was below the touched way's old age gains one, and the other ways keep their age.
- R4: The victim on an allocating miss is the lowest-index Invalid way. When no way is Invalid, it is the way of age WAYS-1. resp_way reports the victim.
- R5: An allocating miss raises fill_valid with the line-aligned address (low OFF bits zero). A read or prefetch miss leaves the new line Exclusive. A hit never raises fill_valid or wb_valid.
- R6: When an allocating miss replaces a Modified line, wb_valid rises with that line's address. The eviction counter counts every valid victim, and the dirty-eviction counter counts the Modified ones.
- R7: A write hit in write-back mode makes the line Modified. With write-through set, every write raises wt_valid with its address, hits included. The line is then not made Modified, and a write miss that allocates leaves the line Exclusive.
- R8: With no-write-allocate set, a write miss raises wt_valid and neither fill_valid nor any change to the set.
- R9: A prefetch miss allocates a line with its prefetch flag set. The first demand hit on it clears the flag and increments the prefetched-used counter once. A prefetch hit changes nothing in the set.
- R10: Counters track demand reads, read misses, writes, write misses, prefetches, prefetch misses, prefetched lines used, evictions, dirty evictions and flushes.
- R11: A snoop update sets the state of the line matching its line address to the given code. An Invalid code also clears the line's prefetch flag. A snoop that matches no line changes nothing.
- R12: A flush raises busy and increments the flush counter. It then visits line set*WAYS+way in ascending order, one per cycle, raising wb_valid for each Modified line. It leaves every line Invalid with its flag clear, and busy falls after the last line. Requests made while busy get no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_write_through | input | 1 | Pass every write to the next level |
| cfg_no_write_alloc | input | 1 | Do not allocate on write miss |
| req_valid | input | 1 | Request present |
| req_write | input | 1 | Request is a write |
| req_prefetch | input | 1 | Request is a prefetch (read type) |
| req_addr | input | ADDR_W | Request physical address |
| snoop_valid | input | 1 | Snoop update present |
| snoop_line | input | ADDR_W-OFF | Line address of the snoop |
| snoop_state | input | 2 | New MESI code |
| flush_start | input | 1 | Start a whole-cache flush |
| peek_set | input | IDX | Set to show on peek outputs |
| peek_way | input | log2(WAYS) | Way to show on peek outputs |
| busy | output | 1 | Flush in progress |
| resp_valid | output | 1 | Response strobe |
| resp_hit | output | 1 | Request hit |
| resp_way | output | log2(WAYS) | Way hit or victim way |
| fill_valid | output | 1 | Line fill request |
| fill_addr | output | ADDR_W | Fill line address |
| wb_valid | output | 1 | Writeback request |
| wb_addr | output | ADDR_W | Writeback line address |
| wt_valid | output | 1 | Write-through request |
| wt_addr | output | ADDR_W | Write-through address |
| peek_state | output | 2 | MESI code of peeked line |
| peek_tag | output | TAG | Tag of peeked line |
| peek_age | output | log2(WAYS) | Age of peeked line |
| peek_pf | output | 1 | Prefetch flag of peeked line |
| cnt_rd_acc | output | CNT_W | Demand reads |
| cnt_rd_miss | output | CNT_W | Read misses |
| cnt_wr_acc | output | CNT_W | Writes |
| cnt_wr_miss | output | CNT_W | Write misses |
| cnt_pf_acc | output | CNT_W | Prefetches |
| cnt_pf_miss | output | CNT_W | Prefetch misses |
| cnt_pf_used | output | CNT_W | Prefetched lines used |
| cnt_evict | output | CNT_W | Valid lines evicted |
| cnt_evict_dirty | output | CNT_W | Modified lines evicted |
| cnt_flush | output | CNT_W | Flushes |

## Verification
The properties assume that in any cycle at most one of request, snoop and flush start is raised, and that no snoop arrives while busy. The bench drives every operation from a task that raises exactly one of them for a single cycle and returns to idle before the next one, so this assumption always holds. A prefetch is taken as read-type whatever req_write says. The bench only issues prefetches with req_write low, so the write-through property never has to cover a prefetch. Counters are assumed not to wrap; runs stay far below their range.

// File: rtl/cache_tag_ctrl.sv
module cache_tag_ctrl #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 16,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 64,
  parameter int CNT_W      = 32,
  localparam int OFF_W = $clog2(LINE_BYTES),
  localparam int IDX_W = $clog2(SETS),
  localparam int AGE_W = $clog2(WAYS),
  localparam int TAG_W = ADDR_W - OFF_W - IDX_W
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cfg_write_through,
  input  logic                    cfg_no_write_alloc,
  input  logic                    req_valid,
  input  logic                    req_write,
  input  logic                    req_prefetch,
  input  logic [ADDR_W-1:0]       req_addr,
  input  logic                    snoop_valid,
  input  logic [ADDR_W-1:OFF_W]   snoop_line,
  input  logic [1:0]              snoop_state,
  input  logic                    flush_start,
  input  logic [IDX_W-1:0]        peek_set,
  input  logic [AGE_W-1:0]        peek_way,
  output logic                    busy,
  output logic                    resp_valid,
  output logic                    resp_hit,
  output logic [AGE_W-1:0]        resp_way,
  output logic                    fill_valid,
  output logic [ADDR_W-1:0]       fill_addr,
  output logic                    wb_valid,
  output logic [ADDR_W-1:0]       wb_addr,
  output logic                    wt_valid,
  output logic [ADDR_W-1:0]       wt_addr,
  output logic [1:0]              peek_state,
  output logic [TAG_W-1:0]        peek_tag,
  output logic [AGE_W-1:0]        peek_age,
  output logic                    peek_pf,
  output logic [CNT_W-1:0]        cnt_rd_acc,
  output logic [CNT_W-1:0]        cnt_rd_miss,
  output logic [CNT_W-1:0]        cnt_wr_acc,
  output logic [CNT_W-1:0]        cnt_wr_miss,
  output logic [CNT_W-1:0]        cnt_pf_acc,
  output logic [CNT_W-1:0]        cnt_pf_miss,
  output logic [CNT_W-1:0]        cnt_pf_used,
  output logic [CNT_W-1:0]        cnt_evict,
  output logic [CNT_W-1:0]        cnt_evict_dirty,
  output logic [CNT_W-1:0]        cnt_flush
);
  localparam int LN_W = IDX_W + AGE_W;
  localparam logic [1:0] ST_I = 2'd0, ST_E = 2'd2, ST_M = 2'd3;
  localparam logic [CNT_W-1:0] C1 = CNT_W'(1);
  localparam logic [AGE_W-1:0] A1 = AGE_W'(1);
  localparam logic [AGE_W-1:0] A_OLD = AGE_W'(WAYS - 1);
  localparam logic [LN_W-1:0] F_LAST = LN_W'(SETS * WAYS - 1);

  logic [1:0]       st_q  [SETS][WAYS];
  logic [TAG_W-1:0] tag_q [SETS][WAYS];
  logic [AGE_W-1:0] age_q [SETS][WAYS];
  logic             pf_q  [SETS][WAYS];
  logic [LN_W-1:0]  fptr;

  wire [IDX_W-1:0] r_idx = req_addr[OFF_W +: IDX_W];
  wire [TAG_W-1:0] r_tag = req_addr[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] s_idx = snoop_line[OFF_W +: IDX_W];
  wire [TAG_W-1:0] s_tag = snoop_line[ADDR_W-1 -: TAG_W];
  wire [IDX_W-1:0] f_set = fptr[LN_W-1:AGE_W];
  wire [AGE_W-1:0] f_way = fptr[AGE_W-1:0];

  logic             hit, inv_any, s_hit;
  logic [AGE_W-1:0] hit_way, inv_way, lru_way, s_way;

  always_comb begin
    hit = 1'b0; hit_way = '0; inv_any = 1'b0; inv_way = '0; lru_way = '0;
    s_hit = 1'b0; s_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (st_q[r_idx][w] == ST_I) begin
        inv_any = 1'b1;
        inv_way = AGE_W'(w);
      end else if (tag_q[r_idx][w] == r_tag) begin
        hit = 1'b1;
        hit_way = AGE_W'(w);
      end
      if (age_q[r_idx][w] == A_OLD) lru_way = AGE_W'(w);
      if (st_q[s_idx][w] != ST_I && tag_q[s_idx][w] == s_tag) begin
        s_hit = 1'b1;
        s_way = AGE_W'(w);
      end
    end
  end

  wire [AGE_W-1:0] victim  = inv_any ? inv_way : lru_way;
  wire [AGE_W-1:0] tw      = hit ? hit_way : victim;
  wire [AGE_W-1:0] old_age = age_q[r_idx][tw];
  wire [1:0]       vic_st  = st_q[r_idx][victim];
  wire [TAG_W-1:0] vic_tag = tag_q[r_idx][victim];

  wire accept = req_valid && !busy && !flush_start;
  wire is_pf  = req_prefetch;
  wire is_wr  = req_write && !req_prefetch;
  wire is_rd  = !req_write && !req_prefetch;
  wire alloc  = !hit && !(is_wr && cfg_no_write_alloc);
  wire touch  = hit ? !is_pf : alloc;
  wire wt_go  = is_wr && (cfg_write_through || (!hit && cfg_no_write_alloc));

  assign peek_state = st_q[peek_set][peek_way];
  assign peek_tag   = tag_q[peek_set][peek_way];
  assign peek_age   = age_q[peek_set][peek_way];
  assign peek_pf    = pf_q[peek_set][peek_way];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          st_q[s][w]  <= ST_I;
          tag_q[s][w] <= '0;
          age_q[s][w] <= AGE_W'(w);
          pf_q[s][w]  <= 1'b0;
        end
      fptr <= '0; busy <= 1'b0;
      resp_valid <= 1'b0; resp_hit <= 1'b0; resp_way <= '0;
      fill_valid <= 1'b0; fill_addr <= '0;
      wb_valid <= 1'b0; wb_addr <= '0;
      wt_valid <= 1'b0; wt_addr <= '0;
      cnt_rd_acc <= '0; cnt_rd_miss <= '0; cnt_wr_acc <= '0; cnt_wr_miss <= '0;
      cnt_pf_acc <= '0; cnt_pf_miss <= '0; cnt_pf_used <= '0;
      cnt_evict <= '0; cnt_evict_dirty <= '0; cnt_flush <= '0;
    end else begin
      resp_valid <= 1'b0;
      fill_valid <= 1'b0;
      wb_valid   <= 1'b0;
      wt_valid   <= 1'b0;
      if (busy) begin
        if (st_q[f_set][f_way] == ST_M) begin
          wb_valid <= 1'b1;
          wb_addr  <= {tag_q[f_set][f_way], f_set, {OFF_W{1'b0}}};
        end
        st_q[f_set][f_way] <= ST_I;
        pf_q[f_set][f_way] <= 1'b0;
        fptr <= fptr + LN_W'(1);
        if (fptr == F_LAST) busy <= 1'b0;
      end else if (flush_start) begin
        busy <= 1'b1;
        fptr <= '0;
        cnt_flush <= cnt_flush + C1;
      end else if (accept) begin
        resp_valid <= 1'b1;
        resp_hit   <= hit;
        resp_way   <= tw;
        if (is_rd) begin
          cnt_rd_acc <= cnt_rd_acc + C1;
          if (!hit) cnt_rd_miss <= cnt_rd_miss + C1;
        end
        if (is_wr) begin
          cnt_wr_acc <= cnt_wr_acc + C1;
          if (!hit) cnt_wr_miss <= cnt_wr_miss + C1;
        end
        if (is_pf) begin
          cnt_pf_acc <= cnt_pf_acc + C1;
          if (!hit) cnt_pf_miss <= cnt_pf_miss + C1;
        end
        if (touch)
          for (int w = 0; w < WAYS; w++)
            if (AGE_W'(w) == tw) age_q[r_idx][w] <= '0;
            else if (age_q[r_idx][w] < old_age) age_q[r_idx][w] <= age_q[r_idx][w] + A1;
        if (hit && !is_pf) begin
          if (pf_q[r_idx][tw]) begin
            pf_q[r_idx][tw] <= 1'b0;
            cnt_pf_used <= cnt_pf_used + C1;
          end
          if (is_wr && !cfg_write_through) st_q[r_idx][tw] <= ST_M;
        end
        if (alloc) begin
          if (vic_st != ST_I) cnt_evict <= cnt_evict + C1;
          if (vic_st == ST_M) begin
            cnt_evict_dirty <= cnt_evict_dirty + C1;
            wb_valid <= 1'b1;
            wb_addr  <= {vic_tag, r_idx, {OFF_W{1'b0}}};
          end
          tag_q[r_idx][tw] <= r_tag;
          st_q[r_idx][tw]  <= (is_wr && !cfg_write_through) ? ST_M : ST_E;
          pf_q[r_idx][tw]  <= is_pf;
          fill_valid <= 1'b1;
          fill_addr  <= {r_tag, r_idx, {OFF_W{1'b0}}};
        end
        if (wt_go) begin
          wt_valid <= 1'b1;
          wt_addr  <= req_addr;
        end
      end else if (snoop_valid && s_hit) begin
        st_q[s_idx][s_way] <= snoop_state;
        if (snoop_state == ST_I) pf_q[s_idx][s_way] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/cache_tag_ctrl_chk.sv
module cache_tag_ctrl_chk #(
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 32,
  parameter int OFF_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_write,
  input logic              req_prefetch,
  input logic              cfg_write_through,
  input logic              flush_start,
  input logic              busy,
  input logic              resp_valid,
  input logic              resp_hit,
  input logic              fill_valid,
  input logic [ADDR_W-1:0] fill_addr,
  input logic              wb_valid,
  input logic              wt_valid,
  input logic [CNT_W-1:0]  cnt_rd_acc,
  input logic [CNT_W-1:0]  cnt_rd_miss,
  input logic [CNT_W-1:0]  cnt_evict_dirty,
  input logic [CNT_W-1:0]  cnt_flush
);
  wire acc = req_valid && !busy && !flush_start;

  AST_RESP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n) acc |=> resp_valid); // R2
  AST_NO_SPURIOUS_RESP: assert property (@(posedge clk) disable iff (!rst_n) !acc |=> !resp_valid); // R2
  AST_HIT_NO_NEXT_LEVEL: assert property (@(posedge clk) disable iff (!rst_n) (resp_valid && resp_hit) |-> (!fill_valid && !wb_valid)); // R5
  AST_FILL_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n) fill_valid |-> (fill_addr[OFF_W-1:0] == '0)); // R5
  AST_WT_EVERY_WRITE: assert property (@(posedge clk) disable iff (!rst_n) (acc && req_write && !req_prefetch && cfg_write_through) |=> wt_valid); // R7
  AST_BUSY_SILENT: assert property (@(posedge clk) disable iff (!rst_n) busy |-> (!resp_valid && !fill_valid)); // R12
  AST_FLUSH_COUNT: assert property (@(posedge clk) disable iff (!rst_n) $rose(busy) |-> (cnt_flush == $past(cnt_flush) + CNT_W'(1))); // R12
  AST_DIRTY_EVICT_COUNT: assert property (@(posedge clk) disable iff (!rst_n) (wb_valid && !busy && !$past(busy)) |-> (cnt_evict_dirty == $past(cnt_evict_dirty) + CNT_W'(1))); // R6
  AST_RD_MISS_BOUND: assert property (@(posedge clk) disable iff (!rst_n) cnt_rd_miss <= cnt_rd_acc); // R10
endmodule

bind cache_tag_ctrl cache_tag_ctrl_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .OFF_W(OFF_W)) u_chk (.*);

// File: tb/cache_tag_ctrl_bench.sv
`timescale 1ns/1ps
module cache_tag_ctrl_bench;
  localparam int S = 4, W = 4, AW = 32, OW = 6, IW = 2, TW = AW - OW - IW, CW = 32;
  localparam int NL = S * W;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wt = 1'b0, cfg_nwa = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_prefetch = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic snoop_valid = 1'b0;
  logic [AW-1:OW] snoop_line = '0;
  logic [1:0] snoop_state = '0;
  logic flush_start = 1'b0;
  logic [IW-1:0] peek_set = '0;
  logic [1:0] peek_way = '0;
  logic busy, resp_valid, resp_hit, fill_valid, wb_valid, wt_valid, peek_pf;
  logic [1:0] resp_way, peek_state, peek_age;
  logic [AW-1:0] fill_addr, wb_addr, wt_addr;
  logic [TW-1:0] peek_tag;
  logic [CW-1:0] c0, c1, c2, c3, c4, c5, c6, c7, c8, c9;

  always #4 clk = ~clk;

  cache_tag_ctrl #(.ADDR_W(AW), .SETS(S), .WAYS(W), .LINE_BYTES(64), .CNT_W(CW)) u_cache_tag_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_write_through(cfg_wt), .cfg_no_write_alloc(cfg_nwa),
    .req_valid(req_valid), .req_write(req_write), .req_prefetch(req_prefetch), .req_addr(req_addr),
    .snoop_valid(snoop_valid), .snoop_line(snoop_line), .snoop_state(snoop_state),
    .flush_start(flush_start), .peek_set(peek_set), .peek_way(peek_way),
    .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_way(resp_way),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .wb_valid(wb_valid), .wb_addr(wb_addr),
    .wt_valid(wt_valid), .wt_addr(wt_addr), .peek_state(peek_state), .peek_tag(peek_tag),
    .peek_age(peek_age), .peek_pf(peek_pf),
    .cnt_rd_acc(c0), .cnt_rd_miss(c1), .cnt_wr_acc(c2), .cnt_wr_miss(c3), .cnt_pf_acc(c4),
    .cnt_pf_miss(c5), .cnt_pf_used(c6), .cnt_evict(c7), .cnt_evict_dirty(c8), .cnt_flush(c9));

  int total = 0, bad = 0;
  int m_st [S][W];
  int m_tag[S][W];
  int m_age[S][W];
  int m_pf [S][W];
  int mc[10];

  task automatic check(bit ok, string r, string what, longint act, longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=0x%0h expected=0x%0h", r, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mk_addr(int tsel, int idx, int off);
    return {TW'(32'h00A000 + tsel), IW'(idx), OW'(off)};
  endfunction

  function automatic logic [AW-1:0] line_addr(int tg, int idx);
    return {TW'(tg), IW'(idx), OW'(0)};
  endfunction

  task automatic do_req(bit wr, bit pf, logic [AW-1:0] a);
    int idx, tg, hw, vw, tw, old;
    bit hit, inv, alloc, touch, e_wb, e_wt, iswr, isrd;
    logic [AW-1:0] e_wba;
    idx = int'(a[OW +: IW]);
    tg = int'(a[AW-1 -: TW]);
    iswr = wr && !pf; isrd = !wr && !pf;
    hit = 0; inv = 0; hw = 0; vw = 0;
    for (int w = W - 1; w >= 0; w--) begin
      if (m_st[idx][w] == 0) begin inv = 1; vw = w; end
      else if (m_tag[idx][w] == tg) begin hit = 1; hw = w; end
    end
    if (!inv) for (int w = 0; w < W; w++) if (m_age[idx][w] == W - 1) vw = w;
    alloc = !hit && !(iswr && cfg_nwa);
    touch = hit ? !pf : alloc;
    tw = hit ? hw : vw;
    old = m_age[idx][tw];
    e_wt = iswr && (cfg_wt || (!hit && cfg_nwa));
    e_wb = alloc && m_st[idx][vw] == 3;
    e_wba = line_addr(m_tag[idx][vw], idx);
    if (isrd) begin mc[0]++; if (!hit) mc[1]++; end
    if (iswr) begin mc[2]++; if (!hit) mc[3]++; end
    if (pf) begin mc[4]++; if (!hit) mc[5]++; end
    if (touch)
      for (int w = 0; w < W; w++)
        if (w == tw) m_age[idx][w] = 0;
        else if (m_age[idx][w] < old) m_age[idx][w]++;
    if (hit && !pf) begin
      if (m_pf[idx][tw] != 0) begin m_pf[idx][tw] = 0; mc[6]++; end
      if (iswr && !cfg_wt) m_st[idx][tw] = 3;
    end
    if (alloc) begin
      if (m_st[idx][vw] != 0) mc[7]++;
      if (m_st[idx][vw] == 3) mc[8]++;
      m_tag[idx][vw] = tg;
      m_st[idx][vw] = (iswr && !cfg_wt) ? 3 : 2;
      m_pf[idx][vw] = pf ? 1 : 0;
    end
    req_valid = 1; req_write = wr; req_prefetch = pf; req_addr = a;
    @(negedge clk);
    req_valid = 0; req_write = 0; req_prefetch = 0;
    check(resp_valid === 1'b1, "R2", "resp_valid", longint'(resp_valid), 1);
    check(resp_hit === hit, "R2", "resp_hit", longint'(resp_hit), longint'(hit));
    if (hit || alloc)
      check(resp_way === 2'(tw), hit ? "R2" : "R4", "resp_way", longint'(resp_way), tw);
    check(fill_valid === alloc, "R5", "fill_valid", longint'(fill_valid), longint'(alloc));
    if (alloc) check(fill_addr === line_addr(tg, idx), "R5", "fill_addr", longint'(fill_addr), longint'(line_addr(tg, idx)));
    check(wb_valid === e_wb, "R6", "wb_valid", longint'(wb_valid), longint'(e_wb));
    if (e_wb) check(wb_addr === e_wba, "R6", "wb_addr", longint'(wb_addr), longint'(e_wba));
    check(wt_valid === e_wt, (!hit && cfg_nwa) ? "R8" : "R7", "wt_valid", longint'(wt_valid), longint'(e_wt));
    if (e_wt) check(wt_addr === a, "R7", "wt_addr", longint'(wt_addr), longint'(a));
  endtask

  task automatic do_snoop(logic [AW-1:0] a, int st);
    int idx, tg;
    idx = int'(a[OW +: IW]);
    tg = int'(a[AW-1 -: TW]);
    for (int w = 0; w < W; w++)
      if (m_st[idx][w] != 0 && m_tag[idx][w] == tg) begin
        m_st[idx][w] = st;
        if (st == 0) m_pf[idx][w] = 0;
      end
    snoop_valid = 1; snoop_line = a[AW-1:OW]; snoop_state = 2'(st);
    @(negedge clk);
    snoop_valid = 0;
  endtask

  task automatic scan(string r);
    for (int s = 0; s < S; s++)
      for (int w = 0; w < W; w++) begin
        peek_set = IW'(s); peek_way = 2'(w);
        #0.2;
        check(peek_state === 2'(m_st[s][w]), r, "line state", longint'(peek_state), m_st[s][w]);
        check(peek_age === 2'(m_age[s][w]), "R3", "line age", longint'(peek_age), m_age[s][w]);
        check(peek_pf === (m_pf[s][w] != 0), "R9", "prefetch flag", longint'(peek_pf), m_pf[s][w]);
        if (m_st[s][w] != 0)
          check(peek_tag === TW'(m_tag[s][w]), r, "line tag", longint'(peek_tag), m_tag[s][w]);
      end
  endtask

  task automatic check_cnt();
    logic [CW-1:0] act [10];
    act = '{c0, c1, c2, c3, c4, c5, c6, c7, c8, c9};
    for (int i = 0; i < 10; i++)
      check(act[i] === CW'(mc[i]), i == 6 ? "R9" : (i == 9 ? "R12" : "R10"), $sformatf("counter %0d", i),
            longint'(act[i]), mc[i]);
  endtask

  task automatic do_flush();
    int s, w;
    bit e;
    mc[9]++;
    flush_start = 1;
    @(negedge clk);
    flush_start = 0;
    check(busy === 1'b1, "R12", "busy after flush start", longint'(busy), 1);
    req_valid = 1; req_addr = mk_addr(0, 0, 0);
    for (int k = 0; k < NL; k++) begin
      @(negedge clk);
      req_valid = 0;
      s = k / W; w = k % W;
      e = m_st[s][w] == 3;
      check(wb_valid === e, "R12", "flush wb_valid", longint'(wb_valid), longint'(e));
      if (e) check(wb_addr === line_addr(m_tag[s][w], s), "R12", "flush wb_addr",
                   longint'(wb_addr), longint'(line_addr(m_tag[s][w], s)));
      check(resp_valid === 1'b0, "R12", "no response while busy", longint'(resp_valid), 0);
      m_st[s][w] = 0; m_pf[s][w] = 0;
    end
    check(busy === 1'b0, "R12", "busy after walk", longint'(busy), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL R12 watchdog: actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int op, ts, ix;
    void'($urandom(32'd1234));
    for (int s = 0; s < S; s++)
      for (int w = 0; w < W; w++) begin
        m_st[s][w] = 0; m_tag[s][w] = 0; m_age[s][w] = w; m_pf[s][w] = 0;
      end
    for (int i = 0; i < 10; i++) mc[i] = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check(!busy && !resp_valid && !fill_valid && !wb_valid && !wt_valid, "R1", "idle outputs",
          longint'({busy, resp_valid, fill_valid, wb_valid, wt_valid}), 0);
    scan("R1");
    check_cnt();
    @(negedge clk);

    for (int t = 0; t < 4; t++) do_req(0, 0, mk_addr(t, 0, 5));
    do_req(0, 0, mk_addr(1, 0, 9));
    scan("R3");
    @(negedge clk);
    do_req(1, 0, mk_addr(2, 0, 0));
    do_req(0, 0, mk_addr(0, 0, 0));
    do_req(0, 0, mk_addr(1, 0, 0));
    do_req(0, 0, mk_addr(3, 0, 0));
    do_req(0, 0, mk_addr(4, 0, 0));
    scan("R6");
    @(negedge clk);
    do_req(0, 1, mk_addr(5, 1, 0));
    do_req(0, 1, mk_addr(5, 1, 0));
    scan("R9");
    @(negedge clk);
    do_req(0, 0, mk_addr(5, 1, 3));
    do_req(1, 0, mk_addr(5, 1, 3));
    scan("R9");
    @(negedge clk);
    cfg_nwa = 1;
    do_req(1, 0, mk_addr(6, 2, 4));
    scan("R8");
    @(negedge clk);
    cfg_nwa = 0; cfg_wt = 1;
    do_req(1, 0, mk_addr(0, 0, 8));
    do_req(1, 0, mk_addr(7, 3, 8));
    scan("R7");
    @(negedge clk);
    cfg_wt = 0;
    do_snoop(mk_addr(9, 0, 0), 0);
    do_snoop(mk_addr(0, 0, 0), 1);
    do_snoop(mk_addr(3, 0, 0), 0);
    scan("R11");
    @(negedge clk);
    check_cnt();
    do_flush();
    scan("R12");
    @(negedge clk);
    check_cnt();

    for (int n = 0; n < 900; n++) begin
      if (n % 150 == 0) begin
        cfg_wt = (n / 150) % 2 == 1;
        cfg_nwa = (n / 300) % 2 == 1;
      end
      op = int'($urandom_range(99));
      ts = int'($urandom_range(5));
      ix = int'($urandom_range(S - 1));
      if (op < 55) do_req(0, 0, mk_addr(ts, ix, int'($urandom_range(63))));
      else if (op < 82) do_req(1, 0, mk_addr(ts, ix, int'($urandom_range(63))));
      else if (op < 94) do_req(0, 1, mk_addr(ts, ix, 0));
      else do_snoop(mk_addr(ts, ix, 0), int'($urandom_range(3)));
      if (n % 45 == 44) begin
        scan("R11");
        @(negedge clk);
      end
      if (n == 300 || n == 650) begin
        do_flush();
        check_cnt();
      end
    end
    scan("R3");
    @(negedge clk);
    check_cnt();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule